// File: doc/BRIEF.md
# Shelving Buffer with Dispatch-Time Operand Capture

This block is an eight-entry issue buffer that sits in front of a single execution unit. The front end hands it one instruction per cycle over a ready/valid handshake. No dependency check is made at that point, so a waiting instruction never holds back the instructions behind it. While an instruction is accepted, its two source registers are looked up in a small register file that keeps a valid flag per register. A source whose register is valid is stored as its value. A source whose register is still pending is stored as the register number, and that number then serves as the wait tag.

Results coming back from execution travel on one broadcast bus that carries a register number and a value. The broadcast writes the register file, and every buffered field waiting on that register number takes the value. An entry whose two fields both hold values is ready. Each cycle the oldest ready entry is presented on the issue port, and its slot is freed at the next edge. Younger ready entries may therefore overtake older ones that are still waiting. Accepting an instruction marks its destination register pending in the register file.

Top module: `shelf_station`

## Requirements
- R1: After reset the buffer is empty, `issueValid` is low, `dispReady` is high, and every register is valid and holds zero.
- R2: An instruction offered with `dispValid` high while `dispReady` is high is accepted whatever its source registers are. Its opcode and destination number appear unchanged on the issue port when it issues.
- R3: On acceptance, a source whose register is valid is captured as that register's current value. A source whose register is pending is captured as a wait tag.
- R4: Acceptance clears the valid flag of the instruction's destination register. A broadcast writes its value into the named register and sets that flag. If both hit the same register in one cycle, the register ends up pending.
- R5: A broadcast fills every buffered field that is waiting on the broadcast register number, in every entry at once.
- R6: `issueValid` is high only when some buffered entry holds values in both fields. `issueA` and `issueB` then carry exactly those values.
- R7: Among the ready entries, the one accepted earliest is issued. At most one entry issues per cycle, and its slot is released at the same edge. A younger ready entry issues before an older entry that is still waiting.
- R8: A broadcast in the same cycle that an instruction is accepted, naming one of its pending source registers, is captured into that source directly.
- R9: `dispReady` is low exactly when eight entries are held. An instruction offered while it is low is not taken and changes no state.
- R10: An entry accepted or filled at a clock edge can be issued from the cycle after that edge. The issue port reflects stored state only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | An instruction is offered |
| dispReady | output | 1 | Buffer can take an instruction |
| dispOp | input | 4 | Opcode of the offered instruction |
| dispDst | input | 4 | Destination register number |
| dispSrcA | input | 4 | First source register number |
| dispSrcB | input | 4 | Second source register number |
| wbValid | input | 1 | Result broadcast present |
| wbTag | input | 4 | Register number of the broadcast result |
| wbData | input | 32 | Broadcast result value |
| issueValid | output | 1 | An entry is issued this cycle |
| issueOp | output | 4 | Opcode of the issued entry |
| issueDst | output | 4 | Destination register of the issued entry |
| issueA | output | 32 | First operand value of the issued entry |
| issueB | output | 32 | Second operand value of the issued entry |

## Verification
Every cycle, the bound checker confirms three things: the stall tracks its own count of accepted and issued instructions, the buffer never exceeds eight entries, and an issue comes only from an occupied slot whose operand fields are both complete. Operand correctness needs the bench's scenarios. That covers the value captured at acceptance, wakeup by a later broadcast, the bypass of a same-cycle broadcast, and a destination staying pending when it is cleared and written in one cycle. Oldest-first ordering and younger-passes-waiting ordering also need the scenarios, and the bench compares them against its own register file and queue model.

// File: rtl/shelf_pkg.sv
package shelf_pkg;
  localparam int DEPTH  = 8;
  localparam int NREG   = 16;
  localparam int DATA_W = 32;
  localparam int OP_W   = 4;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TAG_W = $clog2(NREG);

  // A source field: either a value (ok=1) or a wait tag in the low bits (ok=0)
  typedef struct packed {
    logic              ok;
    logic [DATA_W-1:0] body;
  } opnd_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    opnd_t            a;
    opnd_t            b;
  } slot_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             take;
    logic             fire;
    logic [IDX_W-1:0] fireIdx;
    logic [IDX_W-1:0] putIdx;
  } strobe_t;

  function automatic opnd_t snoop(opnd_t f, logic wv, logic [TAG_W-1:0] wt,
                                  logic [DATA_W-1:0] wd);
    opnd_t r;
    r = f;
    if (!f.ok && wv && (f.body[TAG_W-1:0] == wt)) begin
      r.ok   = 1'b1;
      r.body = wd;
    end
    return r;
  endfunction

  function automatic opnd_t capture(logic rfOk, logic [DATA_W-1:0] rfVal,
                                    logic [TAG_W-1:0] rs, logic wv,
                                    logic [TAG_W-1:0] wt, logic [DATA_W-1:0] wd);
    opnd_t r;
    if (rfOk) begin
      r.ok   = 1'b1;
      r.body = rfVal;
    end else if (wv && (wt == rs)) begin
      r.ok   = 1'b1;
      r.body = wd;
    end else begin
      r.ok   = 1'b0;
      r.body = DATA_W'(rs);
    end
    return r;
  endfunction
endpackage

// File: rtl/shelf_ctrl.sv
module shelf_ctrl
  import shelf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [DEPTH-1:0] opsReady,
  output logic             dispReady,
  output logic             issueValid,
  output strobe_t          strobe
);
  logic [CNT_W-1:0] fill;
  logic [DEPTH-1:0] held;
  logic [DEPTH-1:0] eligible;
  logic             found;
  logic [IDX_W-1:0] pick;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gHeld
      assign held[g] = (CNT_W'(g) < fill);
    end
  endgenerate

  assign eligible = held & opsReady;

  // Slots are kept in age order, so the lowest ready index is the oldest
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eligible[i] && !found) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  assign dispReady      = (fill != CNT_W'(DEPTH));
  assign issueValid     = found;
  assign strobe.take    = dispValid & dispReady;
  assign strobe.fire    = found;
  assign strobe.fireIdx = pick;
  assign strobe.putIdx  = IDX_W'(fill - CNT_W'(found));

  always_ff @(posedge clk) begin
    if (!rstN) fill <= '0;
    else       fill <= fill + CNT_W'(strobe.take) - CNT_W'(found);
  end
endmodule

// File: rtl/shelf_datapath.sv
module shelf_datapath
  import shelf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [TAG_W-1:0]  dispDst,
  input  logic [TAG_W-1:0]  dispSrcA,
  input  logic [TAG_W-1:0]  dispSrcB,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbData,
  output logic [DEPTH-1:0]  opsReady,
  output logic [OP_W-1:0]   issueOp,
  output logic [TAG_W-1:0]  issueDst,
  output logic [DATA_W-1:0] issueA,
  output logic [DATA_W-1:0] issueB
);
  logic [DATA_W-1:0] rfVal [NREG];
  logic [NREG-1:0]   rfOk;
  slot_t             slots [DEPTH];
  slot_t             fresh;

  // Register file with per-register valid flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) rfVal[r] <= '0;
      rfOk <= '1;
    end else begin
      if (wbValid) begin
        rfVal[wbTag] <= wbData;
        rfOk[wbTag]  <= 1'b1;
      end
      if (strobe.take) rfOk[dispDst] <= 1'b0;
    end
  end

  // Operand capture for the incoming instruction, with same-cycle bypass
  always_comb begin
    fresh.op  = dispOp;
    fresh.dst = dispDst;
    fresh.a   = capture(rfOk[dispSrcA], rfVal[dispSrcA], dispSrcA, wbValid, wbTag, wbData);
    fresh.b   = capture(rfOk[dispSrcB], rfVal[dispSrcB], dispSrcB, wbValid, wbTag, wbData);
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gSlot
      slot_t moved;
      slot_t nextSlot;

      if (g < DEPTH - 1) begin : gShift
        always_comb begin
          if (strobe.fire && (IDX_W'(g) >= strobe.fireIdx)) moved = slots[g+1];
          else                                              moved = slots[g];
        end
      end else begin : gLast
        assign moved = slots[g];
      end

      always_comb begin
        if (strobe.take && (strobe.putIdx == IDX_W'(g))) begin
          nextSlot = fresh;
        end else begin
          nextSlot     = moved;
          nextSlot.a   = snoop(moved.a, wbValid, wbTag, wbData);
          nextSlot.b   = snoop(moved.b, wbValid, wbTag, wbData);
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) slots[g] <= '0;
        else       slots[g] <= nextSlot;
      end

      assign opsReady[g] = slots[g].a.ok & slots[g].b.ok;
    end
  endgenerate

  assign issueOp  = slots[strobe.fireIdx].op;
  assign issueDst = slots[strobe.fireIdx].dst;
  assign issueA   = slots[strobe.fireIdx].a.body;
  assign issueB   = slots[strobe.fireIdx].b.body;
endmodule

// File: rtl/shelf_station.sv
module shelf_station
  import shelf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  output logic              dispReady,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [TAG_W-1:0]  dispDst,
  input  logic [TAG_W-1:0]  dispSrcA,
  input  logic [TAG_W-1:0]  dispSrcB,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbData,
  output logic              issueValid,
  output logic [OP_W-1:0]   issueOp,
  output logic [TAG_W-1:0]  issueDst,
  output logic [DATA_W-1:0] issueA,
  output logic [DATA_W-1:0] issueB
);
  strobe_t          strobe;
  logic [DEPTH-1:0] opsReady;

  shelf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .opsReady(opsReady),
    .dispReady(dispReady), .issueValid(issueValid), .strobe(strobe)
  );

  shelf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dispOp(dispOp), .dispDst(dispDst), .dispSrcA(dispSrcA), .dispSrcB(dispSrcB),
    .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData),
    .opsReady(opsReady), .issueOp(issueOp), .issueDst(issueDst),
    .issueA(issueA), .issueB(issueB)
  );
endmodule

// File: rtl/shelf_station_chk.sv
module shelf_station_chk
  import shelf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic             dispReady,
  input logic             issueValid,
  input logic [DEPTH-1:0] opsReady,
  input logic [IDX_W-1:0] fireIdx
);
  int unsigned held;

  always_ff @(posedge clk) begin
    if (!rstN) held <= 0;
    else       held <= held + ((dispValid && dispReady) ? 1 : 0) - (issueValid ? 1 : 0);
  end

  // R6
  issue_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> opsReady[fireIdx]);

  // R7
  issue_occupied_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (int'(fireIdx) < int'(held)));

  // R9
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dispReady |-> (held == DEPTH));

  // R2
  accept_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (held < DEPTH) |-> dispReady);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    held <= DEPTH);
endmodule

bind shelf_station shelf_station_chk u_chk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
  .issueValid(issueValid), .opsReady(opsReady), .fireIdx(strobe.fireIdx)
);

// File: tb/shelf_station_bench.sv
module shelf_station_bench;
  import shelf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NPEND      = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              dispValid;
  logic              dispReady;
  logic [OP_W-1:0]   dispOp;
  logic [TAG_W-1:0]  dispDst, dispSrcA, dispSrcB;
  logic              wbValid;
  logic [TAG_W-1:0]  wbTag;
  logic [DATA_W-1:0] wbData;
  logic              issueValid;
  logic [OP_W-1:0]   issueOp;
  logic [TAG_W-1:0]  issueDst;
  logic [DATA_W-1:0] issueA, issueB;

  shelf_station u_shelf_station (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [OP_W-1:0]   mOp  [DEPTH];
  logic [TAG_W-1:0]  mDst [DEPTH];
  logic              mAok [DEPTH];
  logic              mBok [DEPTH];
  logic [DATA_W-1:0] mA   [DEPTH];
  logic [DATA_W-1:0] mB   [DEPTH];
  int                mCnt;
  logic [DATA_W-1:0] mRf  [NREG];
  logic              mRfOk[NREG];

  // execution unit model
  logic              pUse [NPEND];
  logic [TAG_W-1:0]  pTag [NPEND];
  logic [DATA_W-1:0] pData[NPEND];
  int                pDue [NPEND];
  logic              euHold;
  int                cyc;

  int  nChk = 0;
  int  nBad = 0;
  logic done = 1'b0;

  function automatic logic [DATA_W-1:0] euResult(logic [OP_W-1:0] op,
                                                 logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return op[0] ? (a + b + DATA_W'(op)) : ((a ^ b) + DATA_W'(op));
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One cycle: check outputs, drive inputs, advance the model, cross an edge.
  task automatic step(input logic dv, input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                      input logic [TAG_W-1:0] sa, input logic [TAG_W-1:0] sb,
                      input logic fw, input logic [TAG_W-1:0] ft, input logic [DATA_W-1:0] fd,
                      input string req);
    int sel;
    logic wv;
    logic [TAG_W-1:0] wt;
    logic [DATA_W-1:0] wd;
    logic acc;
    logic [OP_W-1:0] iOp;
    logic [TAG_W-1:0] iDst;
    logic [DATA_W-1:0] iA, iB;
    sel = -1;
    for (int i = 0; i < mCnt; i++) if (sel < 0 && mAok[i] && mBok[i]) sel = i;
    chk("R9", "dispReady", 64'(dispReady), 64'(mCnt < DEPTH));
    chk("R6", "issueValid", 64'(issueValid), 64'(sel >= 0));
    if (sel >= 0) begin
      chk("R7", "issueOp", 64'(issueOp), 64'(mOp[sel]));
      chk("R2", "issueDst", 64'(issueDst), 64'(mDst[sel]));
      chk(req, "issueA", 64'(issueA), 64'(mA[sel]));
      chk(req, "issueB", 64'(issueB), 64'(mB[sel]));
    end
    wv = 1'b0; wt = '0; wd = '0;
    if (fw) begin
      wv = 1'b1; wt = ft; wd = fd;
    end else if (!euHold) begin
      for (int p = 0; p < NPEND; p++) begin
        if (!wv && pUse[p] && pDue[p] <= cyc) begin
          wv = 1'b1; wt = pTag[p]; wd = pData[p]; pUse[p] = 1'b0;
        end
      end
    end
    dispValid = dv; dispOp = op; dispDst = dst; dispSrcA = sa; dispSrcB = sb;
    wbValid = wv; wbTag = wt; wbData = wd;
    acc = dv && (mCnt < DEPTH);
    iOp = '0; iDst = '0; iA = '0; iB = '0;
    if (sel >= 0) begin
      iOp = mOp[sel]; iDst = mDst[sel]; iA = mA[sel]; iB = mB[sel];
      for (int i = sel; i < mCnt - 1; i++) begin
        mOp[i] = mOp[i+1]; mDst[i] = mDst[i+1];
        mAok[i] = mAok[i+1]; mBok[i] = mBok[i+1];
        mA[i] = mA[i+1]; mB[i] = mB[i+1];
      end
      mCnt--;
    end
    for (int i = 0; i < mCnt; i++) begin
      if (wv && !mAok[i] && mA[i][TAG_W-1:0] == wt) begin mAok[i] = 1'b1; mA[i] = wd; end
      if (wv && !mBok[i] && mB[i][TAG_W-1:0] == wt) begin mBok[i] = 1'b1; mB[i] = wd; end
    end
    if (acc) begin
      mOp[mCnt] = op; mDst[mCnt] = dst;
      if (mRfOk[sa])           begin mAok[mCnt] = 1'b1; mA[mCnt] = mRf[sa]; end
      else if (wv && wt == sa) begin mAok[mCnt] = 1'b1; mA[mCnt] = wd; end
      else                     begin mAok[mCnt] = 1'b0; mA[mCnt] = DATA_W'(sa); end
      if (mRfOk[sb])           begin mBok[mCnt] = 1'b1; mB[mCnt] = mRf[sb]; end
      else if (wv && wt == sb) begin mBok[mCnt] = 1'b1; mB[mCnt] = wd; end
      else                     begin mBok[mCnt] = 1'b0; mB[mCnt] = DATA_W'(sb); end
      mCnt++;
    end
    if (wv) begin mRf[wt] = wd; mRfOk[wt] = 1'b1; end
    if (acc) mRfOk[dst] = 1'b0;
    if (sel >= 0) begin
      for (int p = 0; p < NPEND; p++) begin
        if (!pUse[p] && sel >= 0) begin
          pUse[p] = 1'b1; pTag[p] = iDst; pData[p] = euResult(iOp, iA, iB);
          pDue[p] = cyc + 1 + int'($urandom % 3);
          sel = -1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, '0, '0, 1'b0, '0, '0, req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin : main
    int seedSink;
    seedSink = $urandom(32'h5EED);
    cyc = 0; euHold = 1'b0; mCnt = 0;
    for (int r = 0; r < NREG; r++) begin mRf[r] = '0; mRfOk[r] = 1'b1; end
    for (int p = 0; p < NPEND; p++) begin pUse[p] = 1'b0; pTag[p] = '0; pData[p] = '0; pDue[p] = 0; end
    rstN = 1'b0; dispValid = 1'b0; dispOp = '0; dispDst = '0; dispSrcA = '0; dispSrcB = '0;
    wbValid = 1'b0; wbTag = '0; wbData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1", "issueValid after reset", 64'(issueValid), 64'd0);
    chk("R1", "dispReady after reset", 64'(dispReady), 64'd1);
    step(1'b1, 4'd1, 4'd1, 4'd2, 4'd3, 1'b0, '0, '0, "R1");
    idle(4, "R1");

    // R3/R5/R9/R7: fill with dependents on a pending register, then wake them all
    euHold = 1'b1;
    step(1'b1, 4'd2, 4'd9, 4'd0, 4'd1, 1'b0, '0, '0, "R3");
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, OP_W'(i), TAG_W'(10 + (i % 4)), 4'd9, (i % 2 == 0) ? 4'd9 : 4'd1,
           1'b0, '0, '0, "R3");
    for (int i = 0; i < 3; i++)
      step(1'b1, 4'd7, 4'd15, 4'd0, 4'd0, 1'b0, '0, '0, "R9");
    euHold = 1'b0;
    idle(16, "R5");

    // R7: younger ready passes older waiting
    euHold = 1'b1;
    step(1'b1, 4'd3, 4'd12, 4'd0, 4'd1, 1'b0, '0, '0, "R7");
    step(1'b1, 4'd4, 4'd13, 4'd12, 4'd12, 1'b0, '0, '0, "R7");
    step(1'b1, 4'd5, 4'd14, 4'd0, 4'd1, 1'b0, '0, '0, "R7");
    idle(3, "R7");
    euHold = 1'b0;
    idle(8, "R7");

    // R8: broadcast in the cycle of dispatch is captured directly
    euHold = 1'b1;
    step(1'b1, 4'd6, 4'd5, 4'd0, 4'd0, 1'b0, '0, '0, "R8");
    step(1'b1, 4'd8, 4'd6, 4'd5, 4'd5, 1'b1, 4'd5, 32'hC0FFEE12, "R8");
    idle(3, "R8");
    euHold = 1'b0;
    idle(8, "R8");

    // R4: same-cycle clear and write on one register leaves it pending
    euHold = 1'b1;
    step(1'b1, 4'd9, 4'd7, 4'd0, 4'd0, 1'b1, 4'd7, 32'h1234_5678, "R4");
    step(1'b1, 4'd10, 4'd8, 4'd7, 4'd2, 1'b0, '0, '0, "R4");
    idle(4, "R4");
    euHold = 1'b0;
    idle(8, "R4");

    // R10 and everything else: constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic dv, fw;
      dv = ($urandom % 4) != 0;
      fw = ($urandom % 12) == 0;
      step(dv, OP_W'($urandom), TAG_W'($urandom), TAG_W'($urandom), TAG_W'($urandom),
           fw, TAG_W'($urandom), DATA_W'($urandom), "R10");
    end
    idle(20, "R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule